// File: doc/BRIEF.md
# Cache Event Counter Bank

This block holds four free-running event counters for a cache controller. Each counter carries its own event selector and a clear-on-read flag. Every cycle the cache pipeline presents single-bit strobes for hits and misses, together with multi-valued occupancy counts. Each counter adds the contribution of the event it selects. Occupancy events can add anything from zero up to the number of fill-buffer entries in one cycle.

Software programs a counter through a write port that carries an index, an event code and the clear flag. Reprogramming never disturbs the accumulated value. Software reads a counter through a read port. The value appears one cycle after the request, qualified by a valid strobe. When the counter's clear flag is set, the read also restarts the counter.

A two-state machine runs the read port. In `RD_IDLE` no response is pending. The transition *request* (`rd_en` high) leads to `RD_RESP`, which drives `rd_valid` for one cycle. From `RD_RESP`, *chain* (`rd_en` high again) stays in `RD_RESP`, and *drain* (`rd_en` low) returns to `RD_IDLE`.

Top module: `cperf_bank`

## Requirements
- R1: After reset every counter holds 0, selects event code 0 with its clear flag off, and `rd_valid` is low.
- R2: There are NUM_CTR (default 4) counters, indexed 0 to NUM_CTR-1. A write to one index leaves the selector, flag and count of the other counters unchanged.
- R3: Single-strobe codes behave as follows. Code 0 adds 1 every cycle. Code 1 adds the instruction-miss strobe, code 2 the instruction-hit strobe, code 3 the data-miss strobe and code 4 the data-hit strobe. Code 5 adds the number of miss strobes (instruction plus data, 0 to 2). Code 6 adds the number of hit strobes.
- R4: Occupancy codes add a count each cycle. Code 7 adds `fb_valid_cnt`, code 8 adds `fb_wait_fb_cnt` and code 9 adds `fb_wait_vb_cnt`, each in the range 0 to FB_ENTRIES.
- R5: Code 10 adds `bank_busy_cnt` and code 11 adds `wdat_busy_cnt`, each in the range 0 to 4.
- R6: Any code from 12 to 255 adds nothing.
- R7: A read request in cycle T makes `rd_valid` high in cycle T+1, with `rd_data` equal to the counter value before the edge ending cycle T. Without a request, `rd_valid` is low.
- R8: A read of a counter whose clear flag is set returns the old value. The counter then holds exactly the increment of the read cycle.
- R9: A read of a counter whose clear flag is clear leaves that counter accumulating undisturbed.
- R10: Writing a new event code or clear flag leaves the accumulated count unchanged. The write cycle still adds under the old code, and the new code applies from the next cycle.
- R11: Counters wrap modulo 2^CNT_W (default 64) without saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_ifetch_miss | input | 1 | Instruction miss strobe |
| ev_ifetch_hit | input | 1 | Instruction hit strobe |
| ev_data_miss | input | 1 | Data miss strobe |
| ev_data_hit | input | 1 | Data hit strobe |
| fb_valid_cnt | input | FBC_W | Valid fill-buffer entries this cycle |
| fb_wait_fb_cnt | input | FBC_W | Entries waiting on another fill-buffer entry |
| fb_wait_vb_cnt | input | FBC_W | Entries waiting on the victim address buffer |
| bank_busy_cnt | input | 3 | Data banks in use, 0 to 4 |
| wdat_busy_cnt | input | 3 | Write-data holding registers in use, 0 to 4 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Counter index for the write |
| cfg_event | input | 8 | Event code to program |
| cfg_clr_on_read | input | 1 | Clear-on-read flag to program |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Counter index for the read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CNT_W | Counter value returned |

## Verification
Three functions can land on the same edge: a clear-on-read, the increment of that cycle, and a configuration write to the same counter. The bench provokes this by reading each counter while random strobes and occupancy counts are driven. It also reprograms counters while they are counting. Each read is judged against a model that first captures the pre-edge value, then applies clear-or-add using the old code, and only then takes the new configuration.

// File: rtl/cperf_pkg.sv
package cperf_pkg;

    localparam int CODE_W = 8;
    localparam int BUSY_W = 3;

    localparam logic [CODE_W-1:0] EVC_CYCLE      = 8'd0;
    localparam logic [CODE_W-1:0] EVC_IMISS      = 8'd1;
    localparam logic [CODE_W-1:0] EVC_IHIT       = 8'd2;
    localparam logic [CODE_W-1:0] EVC_DMISS      = 8'd3;
    localparam logic [CODE_W-1:0] EVC_DHIT       = 8'd4;
    localparam logic [CODE_W-1:0] EVC_ANY_MISS   = 8'd5;
    localparam logic [CODE_W-1:0] EVC_ANY_HIT    = 8'd6;
    localparam logic [CODE_W-1:0] EVC_FB_VALID   = 8'd7;
    localparam logic [CODE_W-1:0] EVC_FB_WAIT_FB = 8'd8;
    localparam logic [CODE_W-1:0] EVC_FB_WAIT_VB = 8'd9;
    localparam logic [CODE_W-1:0] EVC_BANK_BUSY  = 8'd10;
    localparam logic [CODE_W-1:0] EVC_WDAT_BUSY  = 8'd11;
    localparam logic [CODE_W-1:0] EVC_LAST       = EVC_WDAT_BUSY;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

endpackage

// File: rtl/cperf_event_sel.sv
module cperf_event_sel
    import cperf_pkg::*;
#(
    parameter int FBC_W = 5,
    parameter int INC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              ev_ifetch_miss,
    input  logic              ev_ifetch_hit,
    input  logic              ev_data_miss,
    input  logic              ev_data_hit,
    input  logic [FBC_W-1:0]  fb_valid_cnt,
    input  logic [FBC_W-1:0]  fb_wait_fb_cnt,
    input  logic [FBC_W-1:0]  fb_wait_vb_cnt,
    input  logic [BUSY_W-1:0] bank_busy_cnt,
    input  logic [BUSY_W-1:0] wdat_busy_cnt,
    output logic [INC_W-1:0]  inc
);

    always_comb begin
        inc = '0;
        unique case (code)
            EVC_CYCLE:      inc = INC_W'(1);
            EVC_IMISS:      inc = INC_W'(ev_ifetch_miss);
            EVC_IHIT:       inc = INC_W'(ev_ifetch_hit);
            EVC_DMISS:      inc = INC_W'(ev_data_miss);
            EVC_DHIT:       inc = INC_W'(ev_data_hit);
            EVC_ANY_MISS:   inc = INC_W'(ev_ifetch_miss) + INC_W'(ev_data_miss);
            EVC_ANY_HIT:    inc = INC_W'(ev_ifetch_hit) + INC_W'(ev_data_hit);
            EVC_FB_VALID:   inc = INC_W'(fb_valid_cnt);
            EVC_FB_WAIT_FB: inc = INC_W'(fb_wait_fb_cnt);
            EVC_FB_WAIT_VB: inc = INC_W'(fb_wait_vb_cnt);
            EVC_BANK_BUSY:  inc = INC_W'(bank_busy_cnt);
            EVC_WDAT_BUSY:  inc = INC_W'(wdat_busy_cnt);
            default:        inc = '0;
        endcase
    end

    // R6: codes above the last assigned one contribute nothing
    assert_unassigned_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (code > EVC_LAST) |-> (inc == '0));

    // R3: the cycle event always contributes exactly one
    assert_cycle_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code == EVC_CYCLE) |-> (inc == INC_W'(1)));

endmodule

// File: rtl/cperf_counter.sv
module cperf_counter
    import cperf_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int FBC_W = 5,
    parameter int INC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic [CODE_W-1:0] cfg_event,
    input  logic              cfg_clr_on_read,
    input  logic              rd_clr,
    input  logic              ev_ifetch_miss,
    input  logic              ev_ifetch_hit,
    input  logic              ev_data_miss,
    input  logic              ev_data_hit,
    input  logic [FBC_W-1:0]  fb_valid_cnt,
    input  logic [FBC_W-1:0]  fb_wait_fb_cnt,
    input  logic [FBC_W-1:0]  fb_wait_vb_cnt,
    input  logic [BUSY_W-1:0] bank_busy_cnt,
    input  logic [BUSY_W-1:0] wdat_busy_cnt,
    output logic [CNT_W-1:0]  count,
    output logic              clr_flag
);

    logic [CODE_W-1:0] code_q;
    logic              clr_q;
    logic [CNT_W-1:0]  count_q;
    logic [INC_W-1:0]  inc;

    cperf_event_sel #(
        .FBC_W (FBC_W),
        .INC_W (INC_W)
    ) sel_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .code           (code_q),
        .ev_ifetch_miss (ev_ifetch_miss),
        .ev_ifetch_hit  (ev_ifetch_hit),
        .ev_data_miss   (ev_data_miss),
        .ev_data_hit    (ev_data_hit),
        .fb_valid_cnt   (fb_valid_cnt),
        .fb_wait_fb_cnt (fb_wait_fb_cnt),
        .fb_wait_vb_cnt (fb_wait_vb_cnt),
        .bank_busy_cnt  (bank_busy_cnt),
        .wdat_busy_cnt  (wdat_busy_cnt),
        .inc            (inc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= EVC_CYCLE;
            clr_q   <= 1'b0;
            count_q <= '0;
        end else begin
            if (cfg_sel) begin
                code_q <= cfg_event;
                clr_q  <= cfg_clr_on_read;
            end
            if (rd_clr) begin
                count_q <= CNT_W'(inc);
            end else begin
                count_q <= count_q + CNT_W'(inc);
            end
        end
    end

    assign count    = count_q;
    assign clr_flag = clr_q;

    // R10 / R11: without a clear, the count advances by the increment, modulo 2^CNT_W
    assert_accumulate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> (count == CNT_W'($past(count) + CNT_W'($past(inc)))));

    // R8: a clearing read restarts the count at that cycle's increment
    assert_clear_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (count == CNT_W'($past(inc))));

    // R2: configuration held while this counter is not addressed
    assert_cfg_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sel |=> ($stable(code_q) && $stable(clr_flag)));

endmodule

// File: rtl/cperf_read_ctrl.sv
module cperf_read_ctrl
    import cperf_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CNT_W   = 64,
    parameter int IDX_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [IDX_W-1:0]         rd_idx,
    input  logic [NUM_CTR*CNT_W-1:0] cnt_flat,
    input  logic [NUM_CTR-1:0]       clr_flags,
    output logic [NUM_CTR-1:0]       rd_clr,
    output logic                     rd_valid,
    output logic [CNT_W-1:0]         rd_data
);

    rd_state_e        state_q, state_d;
    logic [CNT_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_en)  state_d = RD_RESP;
            RD_RESP: if (!rd_en) state_d = RD_IDLE;
            default:             state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) begin
                data_q <= cnt_flat[rd_idx*CNT_W +: CNT_W];
            end
        end
    end

    always_comb begin
        rd_valid = (state_q == RD_RESP);
        rd_data  = data_q;
        for (int k = 0; k < NUM_CTR; k++) begin
            rd_clr[k] = rd_en && (rd_idx == IDX_W'(k)) && clr_flags[k];
        end
    end

    // R7: a request yields a response on the next cycle
    assert_resp_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R7: no request, no response
    assert_no_spurious_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R8: at most one counter is cleared per cycle
    assert_single_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_clr));

endmodule

// File: rtl/cperf_bank.sv
module cperf_bank
    import cperf_pkg::*;
#(
    parameter int NUM_CTR    = 4,
    parameter int CNT_W      = 64,
    parameter int FB_ENTRIES = 16,
    localparam int IDX_W     = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
    localparam int FBC_W     = $clog2(FB_ENTRIES + 1),
    localparam int INC_W     = (FBC_W > BUSY_W) ? FBC_W : BUSY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ifetch_miss,
    input  logic              ev_ifetch_hit,
    input  logic              ev_data_miss,
    input  logic              ev_data_hit,
    input  logic [FBC_W-1:0]  fb_valid_cnt,
    input  logic [FBC_W-1:0]  fb_wait_fb_cnt,
    input  logic [FBC_W-1:0]  fb_wait_vb_cnt,
    input  logic [BUSY_W-1:0] bank_busy_cnt,
    input  logic [BUSY_W-1:0] wdat_busy_cnt,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CODE_W-1:0] cfg_event,
    input  logic              cfg_clr_on_read,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_data
);

    logic [NUM_CTR*CNT_W-1:0] cnt_flat;
    logic [NUM_CTR-1:0]       clr_flags;
    logic [NUM_CTR-1:0]       rd_clr;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic cfg_sel;
        assign cfg_sel = cfg_we && (cfg_idx == IDX_W'(g));

        cperf_counter #(
            .CNT_W (CNT_W),
            .FBC_W (FBC_W),
            .INC_W (INC_W)
        ) ctr_i (
            .clk             (clk),
            .rst_n           (rst_n),
            .cfg_sel         (cfg_sel),
            .cfg_event       (cfg_event),
            .cfg_clr_on_read (cfg_clr_on_read),
            .rd_clr          (rd_clr[g]),
            .ev_ifetch_miss  (ev_ifetch_miss),
            .ev_ifetch_hit   (ev_ifetch_hit),
            .ev_data_miss    (ev_data_miss),
            .ev_data_hit     (ev_data_hit),
            .fb_valid_cnt    (fb_valid_cnt),
            .fb_wait_fb_cnt  (fb_wait_fb_cnt),
            .fb_wait_vb_cnt  (fb_wait_vb_cnt),
            .bank_busy_cnt   (bank_busy_cnt),
            .wdat_busy_cnt   (wdat_busy_cnt),
            .count           (cnt_flat[g*CNT_W +: CNT_W]),
            .clr_flag        (clr_flags[g])
        );
    end

    cperf_read_ctrl #(
        .NUM_CTR (NUM_CTR),
        .CNT_W   (CNT_W),
        .IDX_W   (IDX_W)
    ) rd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .cnt_flat  (cnt_flat),
        .clr_flags (clr_flags),
        .rd_clr    (rd_clr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // R5: busy inputs stay within the documented range
    assert_busy_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_busy_cnt <= BUSY_W'(4)) && (wdat_busy_cnt <= BUSY_W'(4)));

    // R4: occupancy inputs never exceed the fill-buffer size
    assert_fb_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_valid_cnt <= FBC_W'(FB_ENTRIES)) && (fb_wait_fb_cnt <= FBC_W'(FB_ENTRIES))
        && (fb_wait_vb_cnt <= FBC_W'(FB_ENTRIES)));

endmodule

// File: tb/cperf_bank_tb_top.sv
`timescale 1ns/1ps
module cperf_bank_tb_top;

    localparam int NC  = 4;
    localparam int CW  = 10;
    localparam int FBE = 16;
    localparam int FW  = 5;
    localparam int IW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_im = 0, ev_ih = 0, ev_dm = 0, ev_dh = 0;
    logic [FW-1:0] fbv = '0, fbw = '0, fbvb = '0;
    logic [2:0]    bank = '0, wdat = '0;
    logic          cfg_we = 0;
    logic [IW-1:0] cfg_idx = '0;
    logic [7:0]    cfg_event = '0;
    logic          cfg_clr = 0;
    logic          rd_en = 0;
    logic [IW-1:0] rd_idx = '0;
    logic          rd_valid;
    logic [CW-1:0] rd_data;

    always #2.5 clk = ~clk;

    cperf_bank #(.NUM_CTR(NC), .CNT_W(CW), .FB_ENTRIES(FBE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_ifetch_miss(ev_im), .ev_ifetch_hit(ev_ih),
        .ev_data_miss(ev_dm), .ev_data_hit(ev_dh),
        .fb_valid_cnt(fbv), .fb_wait_fb_cnt(fbw), .fb_wait_vb_cnt(fbvb),
        .bank_busy_cnt(bank), .wdat_busy_cnt(wdat),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_event(cfg_event),
        .cfg_clr_on_read(cfg_clr), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int            checks = 0;
    int            fails = 0;
    logic [CW-1:0] m_cnt [NC];
    logic [7:0]    m_code [NC];
    logic          m_clr [NC];
    logic [15:0]   lfsr = 16'hACE1;
    string         cur_req = "R1";

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_inc(logic [7:0] code);
        case (code)
            8'd0:  return 1;
            8'd1:  return int'(ev_im);
            8'd2:  return int'(ev_ih);
            8'd3:  return int'(ev_dm);
            8'd4:  return int'(ev_dh);
            8'd5:  return int'(ev_im) + int'(ev_dm);
            8'd6:  return int'(ev_ih) + int'(ev_dh);
            8'd7:  return int'(fbv);
            8'd8:  return int'(fbw);
            8'd9:  return int'(fbvb);
            8'd10: return int'(bank);
            8'd11: return int'(wdat);
            default: return 0;
        endcase
    endfunction

    task automatic rand_ev();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        {ev_im, ev_ih, ev_dm, ev_dh} = lfsr[3:0];
        fbv  = FW'(lfsr % 17);
        fbw  = FW'((lfsr >> 3) % 17);
        fbvb = FW'((lfsr >> 6) % 17);
        bank = 3'((lfsr >> 9) % 5);
        wdat = 3'((lfsr >> 11) % 5);
    endtask

    // Advance one cycle: inputs already driven after a falling edge
    task automatic tick();
        bit            rd = rd_en;
        logic [CW-1:0] exp_rd = '0;
        string         tag = cur_req;
        if (rd) exp_rd = m_cnt[rd_idx];
        for (int k = 0; k < NC; k++) begin
            int inc = exp_inc(m_code[k]);
            if (rd && rd_idx == IW'(k) && m_clr[k]) m_cnt[k] = CW'(inc);
            else m_cnt[k] = m_cnt[k] + CW'(inc);
        end
        if (cfg_we) begin
            m_code[cfg_idx] = cfg_event;
            m_clr[cfg_idx]  = cfg_clr;
        end
        @(posedge clk);
        @(negedge clk);
        if (rd) check(rd_valid && rd_data == exp_rd, tag, longint'(rd_data), longint'(exp_rd));
        else    check(!rd_valid, "R7", longint'(rd_valid), 0);
        rd_en  = 0;
        cfg_we = 0;
    endtask

    task automatic prog(int idx, int code, bit clr);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_event = 8'(code); cfg_clr = clr;
        tick();
    endtask

    task automatic read_ctr(int idx);
        rd_en = 1; rd_idx = IW'(idx);
        tick();
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int codes [16] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,200,255};
        for (int k = 0; k < NC; k++) begin
            m_cnt[k] = '0; m_code[k] = 8'd0; m_clr[k] = 1'b0;
        end
        repeat (4) @(negedge clk);
        // R1: outputs idle during reset
        check(!rd_valid && rd_data == '0, "R1", longint'(rd_data), 0);
        rst_n = 1;
        // R1: counters start at zero on the cycle event
        cur_req = "R1";
        for (int k = 0; k < NC; k++) read_ctr(k);

        // R3 R4 R5 R6: sweep every assigned code plus unassigned ones
        for (int i = 0; i < 16; i++) begin
            int k = i % NC;
            cur_req = (codes[i] <= 6) ? "R3" : (codes[i] <= 9) ? "R4" :
                      (codes[i] <= 11) ? "R5" : "R6";
            prog(k, codes[i], 1);
            rand_ev(); read_ctr(k);
            repeat (24) begin rand_ev(); tick(); end
            // R8: clearing read while the event is active
            cur_req = "R8";
            rand_ev(); read_ctr(k);
            rand_ev(); read_ctr(k);
        end

        // R2: all counters kept independent values through the sweep
        cur_req = "R2";
        for (int k = 0; k < NC; k++) begin rand_ev(); read_ctr(k); end

        // R9: non-clearing reads leave the count running
        cur_req = "R9";
        prog(1, 0, 0);
        repeat (5) tick();
        read_ctr(1);
        tick();
        read_ctr(1);

        // R10: reprogram mid-run, count continues
        cur_req = "R10";
        prog(2, 7, 0);
        repeat (10) begin rand_ev(); tick(); end
        rand_ev(); prog(2, 1, 0);
        repeat (10) begin rand_ev(); tick(); end
        rand_ev(); prog(2, 7, 1);
        rand_ev(); read_ctr(2);
        rand_ev(); read_ctr(2);

        // R11: wrap past 2^CW with full fill-buffer occupancy
        cur_req = "R11";
        prog(3, 7, 1);
        fbv = FW'(FBE);
        read_ctr(3);
        repeat (70) tick();
        read_ctr(3);
        check(rd_data == CW'((FBE * 71) % (1 << CW)), "R11",
              longint'(rd_data), longint'((FBE * 71) % (1 << CW)));

        finish_run();
    end

endmodule